// File: doc/BRIEF.md
# Line-Synchronous Alternating-Phase Impulse Gate

This block decides when firing impulses go to a single-phase switch pair driving a transformer. A squared mains-polarity signal is brought into the clock domain. Every edge of that signal marks the start of a mains half-cycle. While an exposure is requested, the block emits one single-cycle impulse strobe per half-cycle. Successive impulses therefore alternate in line polarity.

Two flip-flops carry the polarity memory:

- **Line-reference flop.** It follows the line on every edge. A falling line edge forces it to zero, which keeps it locked to the mains phase.
- **Exposure-phase flop.** It advances only when an impulse is actually fired, and it holds its value between exposures.

Their XOR is the phase-select output. Because the exposure-phase flop remembers the polarity of the last impulse, a new exposure cannot fire until a line edge of the opposite polarity arrives. The transformer core is therefore never driven twice in the same direction across exposure boundaries.

The exposure request is also passed on, one cycle later, as two levels:

- an arm signal for an independent backup timer;
- a release for the external exposure-duration counter.

Top module: `line_impulse_gate`

## Requirements
- R1: The mains-polarity input passes through a two-stage synchronizer. An impulse strobe caused by a line edge is visible in the third clock cycle after the input changes: it is high during the cycle that follows the second rising clock edge after the change.
- R2: After reset, the first impulse of the first exposure fires only on a rising line edge, that is, when the line-polarity input has become 1.
- R3: The first impulse of every exposure has the opposite line polarity from the last impulse of the previous exposure. If an exposure ends without firing, that memory is kept unchanged.
- R4: Within an exposure, a line edge fires an impulse exactly when its new polarity differs from that of the previous impulse. Once the first impulse has fired, every following line edge fires, and the impulses alternate in polarity.
- R5: No impulse strobe is ever issued while the exposure request is low.
- R6: Each impulse strobe is high for exactly one clock cycle.
- R7: The backup-arm and timer-release outputs equal the exposure-request input delayed by one clock cycle.
- R8: Phase-select holds its value across a line edge that fires an impulse. It inverts across a line edge that fires none, whether the block is idle or waiting inside an exposure.
- R9: Synchronous reset (active high) leaves strobe, backup-arm and timer-release at 0 and phase-select at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_pol_i | input | 1 | Squared mains polarity, 1 = positive half-cycle |
| expo_req_i | input | 1 | Exposure request level, synchronous to clk |
| fire_o | output | 1 | Single-cycle impulse strobe, one per fired half-cycle |
| phase_sel_o | output | 1 | XOR of line-reference and exposure-phase flops |
| backup_arm_o | output | 1 | Arm level for the independent backup timer |
| timer_release_o | output | 1 | Release for the external exposure-duration timer |

## Verification
The hardest situation to reach from the ports is an exposure whose first line edge has the same polarity as the previous exposure's last impulse. That edge must be skipped, and an exposure lasting only that one edge must end with no impulse and leave the polarity memory untouched.

The stimulus reaches these cases in two ways. Exposures of random length from one to seven half-cycles are placed back to back, with random idle gaps of zero to three half-cycles; odd and even gap counts then line up both polarity outcomes at the start edge. A directed run of single-edge exposures is added so that skipped and fired starts both occur. Expected strobes per edge come from a bench model of the next permitted polarity.

// File: rtl/lgate_pkg.sv
package lgate_pkg;

    // Number of synchronizer stages required on the line input
    localparam int unsigned SYNC_STAGES_DEF = 2;

    typedef enum logic {
        POL_NEG = 1'b0,
        POL_POS = 1'b1
    } line_pol_e;

    // One sampled view of the line after synchronization
    typedef struct packed {
        logic      evt;   // single-cycle pulse on any line edge
        logic      rise;  // pulse is a rising edge
        line_pol_e lvl;   // synchronized line level
    } line_evt_t;

    // Line-reference flop next value: toggles per edge, falling edge clears
    function automatic logic ref_next(input logic cur, input line_evt_t e);
        logic nxt;
        nxt = cur;
        if (e.evt) begin
            nxt = ~cur;
            if (!e.rise) nxt = 1'b0;
            else         nxt = 1'b1;
        end
        return nxt;
    endfunction

    // An edge may fire when its new level differs from the last fired impulse,
    // i.e. matches the stored "next permitted" polarity
    function automatic logic edge_permitted(input line_pol_e lvl, input logic next_pol);
        return (lvl == line_pol_e'(next_pol));
    endfunction

endpackage

// File: rtl/lgate_line_sync.sv
module lgate_line_sync
    import lgate_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pol_i,
    output line_evt_t ev_o,
    output logic      ref_q_o
);
    localparam int unsigned ST = (STAGES < 2) ? 2 : STAGES;

    logic [ST-1:0] sh;
    logic          prev;
    logic          ref_q;
    line_evt_t     ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            prev <= 1'b0;
        end else begin
            sh   <= {sh[ST-2:0], pol_i};
            prev <= sh[ST-1];
        end
    end

    always_comb begin
        ev.evt  = sh[ST-1] ^ prev;
        ev.rise = sh[ST-1] & ~prev;
        ev.lvl  = line_pol_e'(sh[ST-1]);
    end

    always_ff @(posedge clk) begin
        if (rst) ref_q <= 1'b0;
        else     ref_q <= ref_next(ref_q, ev);
    end

    assign ev_o    = ev;
    assign ref_q_o = ref_q;

    assert_ref_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (ev.evt && !ev.rise) |=> !ref_q);
    assert_ref_set_R8: assert property (@(posedge clk) disable iff (rst)
        ev.rise |=> ref_q);

endmodule

// File: rtl/lgate_expo_phase.sv
module lgate_expo_phase
    import lgate_pkg::*;
#(
    parameter bit START_POL = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      evt_i,
    input  line_pol_e lvl_i,
    input  logic      ref_q_i,
    input  logic      expo_req_i,
    output logic      fire_o,
    output logic      phase_sel_o
);
    logic ex_q;
    logic fire;

    always_comb begin
        fire = evt_i & expo_req_i & edge_permitted(lvl_i, ex_q);
    end

    always_ff @(posedge clk) begin
        if (rst)       ex_q <= START_POL;
        else if (fire) ex_q <= ~ex_q;
    end

    assign fire_o      = fire;
    assign phase_sel_o = ref_q_i ^ ex_q;

    assert_no_fire_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !expo_req_i |-> !fire_o);
    assert_hold_between_R3: assert property (@(posedge clk) disable iff (rst)
        !expo_req_i |=> (ex_q == $past(ex_q)));
    assert_fire_advances_R4: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> (ex_q != $past(ex_q)));

endmodule

// File: rtl/line_impulse_gate.sv
module line_impulse_gate
    import lgate_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
    parameter bit          START_POL   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic line_pol_i,
    input  logic expo_req_i,
    output logic fire_o,
    output logic phase_sel_o,
    output logic backup_arm_o,
    output logic timer_release_o
);
    line_evt_t ev;
    logic      ref_q;
    logic      arm_q;
    logic      rel_q;

    lgate_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pol_i   (line_pol_i),
        .ev_o    (ev),
        .ref_q_o (ref_q)
    );

    lgate_expo_phase #(.START_POL(START_POL)) u_phase (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (ev.evt),
        .lvl_i       (ev.lvl),
        .ref_q_i     (ref_q),
        .expo_req_i  (expo_req_i),
        .fire_o      (fire_o),
        .phase_sel_o (phase_sel_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= 1'b0;
            rel_q <= 1'b0;
        end else begin
            arm_q <= expo_req_i;
            rel_q <= expo_req_i;
        end
    end

    assign backup_arm_o    = arm_q;
    assign timer_release_o = rel_q;

    assert_arm_on_R7: assert property (@(posedge clk) disable iff (rst)
        expo_req_i |=> (backup_arm_o && timer_release_o));
    assert_arm_off_R7: assert property (@(posedge clk) disable iff (rst)
        !expo_req_i |=> (!backup_arm_o && !timer_release_o));

endmodule

// File: tb/line_impulse_gate_bench.sv
`timescale 1ns/1ps
module line_impulse_gate_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_pol = 1'b0;
    logic expo_req = 1'b0;
    logic fire, phase_sel, backup_arm, timer_release;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model state
    bit  exp_next;          // polarity the next impulse must have
    bit  exp_fire;
    int  cyc_since_edge;
    int  step_fires;
    int  fire_off;
    bit  prev_fire;
    bit  prev_expo;
    bit  first_after_rst;
    bit  first_in_expo;
    bit  have_obs;
    bit  last_obs_pol;
    bit  p_prev;

    always #5 clk = ~clk;

    line_impulse_gate u_line_impulse_gate (
        .clk             (clk),
        .rst             (rst),
        .line_pol_i      (line_pol),
        .expo_req_i      (expo_req),
        .fire_o          (fire),
        .phase_sel_o     (phase_sel),
        .backup_arm_o    (backup_arm),
        .timer_release_o (timer_release)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // continuous monitor at the falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            cyc_since_edge++;
            if (fire) begin
                step_fires++;
                fire_off = cyc_since_edge;
                check(expo_req, "R5 strobe with request low", 1, 0);
                check(!prev_fire, "R6 strobe longer than one cycle", 1, 0);
                if (first_after_rst)
                    check(line_pol == 1'b1, "R2 first impulse polarity", line_pol, 1);
                if (first_in_expo && have_obs)
                    check(line_pol != last_obs_pol, "R3 start opposite to last impulse",
                          line_pol, !last_obs_pol);
                first_after_rst = 0;
                first_in_expo   = 0;
                have_obs        = 1;
                last_obs_pol    = line_pol;
            end
            check(backup_arm == prev_expo, "R7 backup arm", backup_arm, prev_expo);
            check(timer_release == prev_expo, "R7 timer release", timer_release, prev_expo);
            prev_fire = fire;
            prev_expo = expo_req;
        end
    end

    task automatic do_reset();
        @(posedge clk); #2;
        line_pol = 1'b0;
        expo_req = 1'b0;
        rst = 1'b1;
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        exp_next = 1'b1;
        first_after_rst = 1;
        first_in_expo = 0;
        have_obs = 0;
        prev_fire = 0;
        prev_expo = 0;
        @(negedge clk);
        check(!fire, "R9 reset strobe", fire, 0);
        check(!backup_arm, "R9 reset arm", backup_arm, 0);
        check(!timer_release, "R9 reset release", timer_release, 0);
        check(phase_sel, "R9 reset phase select", phase_sel, 1);
        p_prev = phase_sel;
    endtask

    // one half-cycle: line edge at start, optional request change at mid
    task automatic step(input int len, input bit do_set, input bit val);
        @(posedge clk); #2;
        line_pol = ~line_pol;
        cyc_since_edge = 0;
        step_fires = 0;
        fire_off = 0;
        exp_fire = expo_req && (line_pol == exp_next);
        if (exp_fire) exp_next = ~exp_next;
        repeat (len / 2) @(posedge clk);
        #2;
        if (exp_fire)
            check(phase_sel == p_prev, "R8 phase held on fired edge", phase_sel, p_prev);
        else
            check(phase_sel != p_prev, "R8 phase inverted on idle edge", phase_sel, !p_prev);
        p_prev = phase_sel;
        if (do_set) begin
            expo_req = val;
            if (val) first_in_expo = 1;
        end
        repeat (len - len / 2) @(posedge clk);
        check(step_fires == int'(exp_fire), "R4 impulses per line edge", step_fires, exp_fire);
        if (exp_fire)
            check(fire_off == 3, "R1 strobe latency", fire_off, 3);
    endtask

    task automatic run_expo(input int nedges, input int gap);
        step($urandom_range(8, 14), 1'b1, 1'b1);
        for (int i = 0; i < nedges - 1; i++) step($urandom_range(8, 14), 1'b0, 1'b0);
        step($urandom_range(8, 14), 1'b1, 1'b0);
        for (int i = 0; i < gap; i++) step($urandom_range(8, 14), 1'b0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // directed: single-edge exposures, both skip and fire at start
        for (int i = 0; i < 6; i++) run_expo(1, i % 2);
        // directed: odd and even impulse counts back to back
        run_expo(3, 0);
        run_expo(4, 0);
        run_expo(2, 1);
        run_expo(5, 2);
        // random exposures
        for (int i = 0; i < 25; i++) run_expo($urandom_range(1, 7), $urandom_range(0, 3));
        // reset mid-run restores the defined starting polarity
        do_reset();
        for (int i = 0; i < 10; i++) run_expo($urandom_range(1, 7), $urandom_range(0, 3));
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule